// File: doc/BRIEF.md
# Calibration DAC Loader Sequencer

This block loads the trim settings for one analog output channel. A request carries an output channel number and a range code. The block reads two 16-bit words from a calibration word store: an offset word and a gain word. It splits each word into a coarse byte (the upper half) and a fine byte (the lower half). It then sends the four bytes, one at a time, over a shared serial line to one 8-bit calibration DAC. Each calibration DAC serves a pair of output channels. After each serial frame, the block latches the frame by briefly pulling that DAC's active-low deselect line low.

Requests arrive over a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. A requester that holds `req_valid` high simply waits through a running sequence. A request raised and then dropped while the block is busy is never taken. Store reads also use valid/ready. The block holds the address steady until the store raises `st_req_ready`. The store answers each read later with a one-cycle `st_rsp_valid`. Only one read is outstanding at a time, and no back-pressure is applied to the response. A one-cycle `done` pulse marks the end of a sequence.

Top module: `caldac_loader`

## Requirements
- R1: After reset, `req_ready` is 1, every `cdac_desel` bit is 1, and `ser_clk`, `done` and `st_req_valid` are 0.
- R2: For channel c and range r, with idx = 2·r + 12·c, the block reads the offset word at address idx+7 first and then the gain word at idx+8.
- R3: A store read address is held stable while `st_req_valid` is high and `st_req_ready` is low. The gain read is issued only after the offset word has returned.
- R4: The target calibration DAC is c/2 (integer division), so the `cdac_desel` bit that goes low is bit c/2. The sub-channel base is 4·(c mod 2).
- R5: Four frames are sent in a fixed order. With base b, offset word O and gain word G, they are: sub-channel b+2 with O[15:8], then b+3 with O[7:0], then b+1 with G[15:8], then b+0 with G[7:0].
- R6: Each frame is 11 bits sent most significant bit first: the 3-bit sub-channel, then the 8-bit value. Each bit is held on `ser_data` for BIT_CYC cycles, and `ser_clk` is high only in the last cycle of that window (default BIT_CYC = 2).
- R7: After the last bit of a frame, exactly one `cdac_desel` bit goes low for LATCH_CYC cycles (default 2) and then returns high. `ser_clk` stays low while any deselect is low.
- R8: `ref_desel` is 1 at all times, so the reference DAC is never selected.
- R9: `done` is high for exactly one cycle. That cycle is the first cycle in which all deselects are high again after the fourth latch. `req_ready` returns to 1 in the following cycle.
- R10: From acceptance until after `done`, `req_ready` is 0. A request raised and dropped during that time starts no store read and no frame.
- R11: A request held valid through a running sequence is accepted on the clock edge right after the `done` cycle. It then runs with the channel and range presented at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_chan | input | 3 | Output channel number |
| req_range | input | 3 | Range code |
| st_req_valid | output | 1 | Store read request valid |
| st_req_ready | input | 1 | Store accepts the read address |
| st_req_addr | output | 7 | Store word address |
| st_rsp_valid | input | 1 | Store read data valid (one cycle) |
| st_rsp_data | input | 16 | Store read data word |
| ser_data | output | 1 | Serial data to the calibration DACs |
| ser_clk | output | 1 | Serial bit strobe |
| cdac_desel | output | 4 | Active-low select, one bit per calibration DAC |
| ref_desel | output | 1 | Reference DAC deselect, held at 1 |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two events can land in the same cycle. One is the `done` pulse that closes a sequence. The other is a new request that has been held valid all along. The bench provokes this by keeping `req_valid` high through a whole run and changing the channel and range after the first acceptance. The check passes only if `req_ready` stays low in the `done` cycle and the second acceptance falls on the very next edge. The frames of the second run must also carry the new channel's sub-channels and bytes. A second case pulses a request in the middle of a run and confirms that no extra acceptance, store read or frame follows.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  localparam int SUB_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int FRAME_W = SUB_W + BYTE_W;

  // sub-channel offsets inside one DAC half (fixed by the DAC wiring)
  localparam logic [1:0] SUB_GAIN_FINE   = 2'd0;
  localparam logic [1:0] SUB_GAIN_COARSE = 2'd1;
  localparam logic [1:0] SUB_OFS_COARSE  = 2'd2;
  localparam logic [1:0] SUB_OFS_FINE    = 2'd3;

  typedef enum logic [2:0] {
    T_IDLE, T_FETCH, T_LOAD, T_SHIFT, T_HOLD, T_DONE
  } seq_state_t;

  // write order is behaviour: coarse offset, fine offset, coarse gain, fine gain
  typedef enum logic [1:0] {
    W_OFS_HI, W_OFS_LO, W_GAIN_HI, W_GAIN_LO
  } step_t;

  typedef enum logic [2:0] {
    F_IDLE, F_REQ_A, F_WAIT_A, F_REQ_B, F_WAIT_B
  } fetch_state_t;

  typedef struct packed {
    logic [SUB_W-1:0]  sub;
    logic [BYTE_W-1:0] val;
  } frame_t;
endpackage

// File: rtl/calseq_fetch.sv
module calseq_fetch
  import calseq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              st_req_valid,
  input  logic              st_req_ready,
  output logic [ADDR_W-1:0] st_req_addr,
  input  logic              st_rsp_valid,
  input  logic [WORD_W-1:0] st_rsp_data,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic              fin
);
  fetch_state_t      fst;
  logic [ADDR_W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst    <= F_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      word_a <= '0;
      word_b <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (fst)
        F_IDLE: if (go) begin
          a_q <= addr_a;
          b_q <= addr_b;
          fst <= F_REQ_A;
        end
        F_REQ_A:  if (st_req_ready) fst <= F_WAIT_A;
        F_WAIT_A: if (st_rsp_valid) begin
          word_a <= st_rsp_data;
          fst    <= F_REQ_B;
        end
        F_REQ_B:  if (st_req_ready) fst <= F_WAIT_B;
        F_WAIT_B: if (st_rsp_valid) begin
          word_b <= st_rsp_data;
          fin    <= 1'b1;
          fst    <= F_IDLE;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

  assign st_req_valid = (fst == F_REQ_A) || (fst == F_REQ_B);
  assign st_req_addr  = (fst == F_REQ_B) ? b_q : a_q;
endmodule

// File: rtl/calseq_shift.sv
module calseq_shift #(
  parameter int FRAME_W = 11,
  parameter int BIT_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               fin
);
  localparam int CYC_W = $clog2(BIT_CYC) + 1;
  localparam int BIT_W = $clog2(FRAME_W) + 1;

  logic               active;
  logic [FRAME_W-1:0] shreg;
  logic [CYC_W-1:0]   cyc;
  logic [BIT_W-1:0]   bits_left;
  logic               win_end;

  assign win_end = active && (cyc == CYC_W'(BIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      shreg     <= '0;
      cyc       <= '0;
      bits_left <= '0;
    end else if (go && !active) begin
      active    <= 1'b1;
      shreg     <= frame_in;
      cyc       <= '0;
      bits_left <= BIT_W'(FRAME_W - 1);
    end else if (active) begin
      if (win_end) begin
        cyc <= '0;
        if (bits_left == '0) begin
          active <= 1'b0;
        end else begin
          shreg     <= {shreg[FRAME_W-2:0], 1'b0};
          bits_left <= bits_left - 1'b1;
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  assign ser_data = active && shreg[FRAME_W-1];
  assign ser_clk  = win_end;
  assign fin      = win_end && (bits_left == '0);
endmodule

// File: rtl/calseq_latch.sv
module calseq_latch #(
  parameter int NUM_DAC   = 4,
  parameter int LATCH_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [$clog2(NUM_DAC)-1:0] dac_sel,
  output logic [NUM_DAC-1:0]         cdac_desel,
  output logic                       fin
);
  localparam int DAC_W = $clog2(NUM_DAC);
  localparam int CNT_W = $clog2(LATCH_CYC) + 1;

  logic             active;
  logic [DAC_W-1:0] tgt;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      tgt    <= '0;
      cnt    <= '0;
    end else if (go && !active) begin
      active <= 1'b1;
      tgt    <= dac_sel;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == CNT_W'(LATCH_CYC - 1)) active <= 1'b0;
      else                              cnt    <= cnt + 1'b1;
    end
  end

  assign fin = active && (cnt == CNT_W'(LATCH_CYC - 1));

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_desel
    assign cdac_desel[g] = !(active && (tgt == DAC_W'(g)));
  end
endmodule

// File: rtl/caldac_loader.sv
module caldac_loader #(
  parameter int NUM_CHAN     = 8,
  parameter int RANGE_W      = 3,
  parameter int ADDR_W       = 7,
  parameter int WORD_BASE    = 7,
  parameter int RANGE_STRIDE = 2,
  parameter int CHAN_STRIDE  = 12,
  parameter int BIT_CYC      = 2,
  parameter int LATCH_CYC    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [$clog2(NUM_CHAN)-1:0]   req_chan,
  input  logic [RANGE_W-1:0]            req_range,
  output logic                          st_req_valid,
  input  logic                          st_req_ready,
  output logic [ADDR_W-1:0]             st_req_addr,
  input  logic                          st_rsp_valid,
  input  logic [calseq_pkg::WORD_W-1:0] st_rsp_data,
  output logic                          ser_data,
  output logic                          ser_clk,
  output logic [NUM_CHAN/2-1:0]         cdac_desel,
  output logic                          ref_desel,
  output logic                          done
);
  import calseq_pkg::*;

  localparam int CHAN_W  = $clog2(NUM_CHAN);
  localparam int NUM_DAC = NUM_CHAN / 2;
  localparam int DAC_W   = $clog2(NUM_DAC);

  seq_state_t       state;
  step_t            step;
  logic [CHAN_W-1:0] chan_q;
  logic              accept;
  logic [ADDR_W-1:0] idx, addr_ofs, addr_gain;
  logic [WORD_W-1:0] word_ofs, word_gain;
  logic              fetch_fin, shift_fin, latch_fin;
  logic              shift_go, latch_go;
  frame_t            cur_frame;
  logic [SUB_W-1:0]  sub_base;
  logic [DAC_W-1:0]  dac_idx;

  assign accept    = req_valid && (state == T_IDLE);
  assign req_ready = (state == T_IDLE);
  assign done      = (state == T_DONE);
  assign ref_desel = 1'b1;

  // word addresses from channel and range
  always_comb begin
    idx       = ADDR_W'(RANGE_STRIDE * int'(req_range) + CHAN_STRIDE * int'(req_chan));
    addr_ofs  = idx + ADDR_W'(WORD_BASE);
    addr_gain = addr_ofs + ADDR_W'(1);
  end

  // DAC pair mapping: even/odd channel picks lower/upper sub-channel half
  assign sub_base = {chan_q[0], 2'b00};
  assign dac_idx  = DAC_W'(chan_q >> 1);

  always_comb begin
    unique case (step)
      W_OFS_HI: begin
        cur_frame.sub = sub_base | {1'b0, SUB_OFS_COARSE};
        cur_frame.val = word_ofs[WORD_W-1:BYTE_W];
      end
      W_OFS_LO: begin
        cur_frame.sub = sub_base | {1'b0, SUB_OFS_FINE};
        cur_frame.val = word_ofs[BYTE_W-1:0];
      end
      W_GAIN_HI: begin
        cur_frame.sub = sub_base | {1'b0, SUB_GAIN_COARSE};
        cur_frame.val = word_gain[WORD_W-1:BYTE_W];
      end
      default: begin
        cur_frame.sub = sub_base | {1'b0, SUB_GAIN_FINE};
        cur_frame.val = word_gain[BYTE_W-1:0];
      end
    endcase
  end

  assign shift_go = (state == T_LOAD);
  assign latch_go = (state == T_SHIFT) && shift_fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= T_IDLE;
      step   <= W_OFS_HI;
      chan_q <= '0;
    end else begin
      unique case (state)
        T_IDLE: if (accept) begin
          chan_q <= req_chan;
          step   <= W_OFS_HI;
          state  <= T_FETCH;
        end
        T_FETCH: if (fetch_fin) state <= T_LOAD;
        T_LOAD:  state <= T_SHIFT;
        T_SHIFT: if (shift_fin) state <= T_HOLD;
        T_HOLD:  if (latch_fin) begin
          if (step == W_GAIN_LO) begin
            state <= T_DONE;
          end else begin
            step  <= step_t'(step + 2'd1);
            state <= T_LOAD;
          end
        end
        T_DONE:  state <= T_IDLE;
        default: state <= T_IDLE;
      endcase
    end
  end

  calseq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (accept),
    .addr_a       (addr_ofs),
    .addr_b       (addr_gain),
    .st_req_valid (st_req_valid),
    .st_req_ready (st_req_ready),
    .st_req_addr  (st_req_addr),
    .st_rsp_valid (st_rsp_valid),
    .st_rsp_data  (st_rsp_data),
    .word_a       (word_ofs),
    .word_b       (word_gain),
    .fin          (fetch_fin)
  );

  calseq_shift #(.FRAME_W(FRAME_W), .BIT_CYC(BIT_CYC)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (shift_go),
    .frame_in (cur_frame),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .fin      (shift_fin)
  );

  calseq_latch #(.NUM_DAC(NUM_DAC), .LATCH_CYC(LATCH_CYC)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (latch_go),
    .dac_sel    (dac_idx),
    .cdac_desel (cdac_desel),
    .fin        (latch_fin)
  );
endmodule

// File: rtl/caldac_loader_chk.sv
module caldac_loader_chk #(
  parameter int ADDR_W  = 7,
  parameter int NUM_DAC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               st_req_valid,
  input logic               st_req_ready,
  input logic [ADDR_W-1:0]  st_req_addr,
  input logic               ser_clk,
  input logic [NUM_DAC-1:0] cdac_desel,
  input logic               done
);
  // R7
  one_dac_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cdac_desel));

  // R7
  quiet_line_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdac_desel != {NUM_DAC{1'b1}}) |-> !ser_clk);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_valid && !st_req_ready) |=> (st_req_valid && $stable(st_req_addr)));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_ready ##1 req_ready));
endmodule

bind caldac_loader caldac_loader_chk #(.ADDR_W(ADDR_W), .NUM_DAC(NUM_CHAN/2)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .st_req_valid (st_req_valid),
  .st_req_ready (st_req_ready),
  .st_req_addr  (st_req_addr),
  .ser_clk      (ser_clk),
  .cdac_desel   (cdac_desel),
  .done         (done)
);

// File: tb/caldac_loader_bench.sv
module caldac_loader_bench;
  localparam int BIT_CYC   = 2;
  localparam int LATCH_CYC = 2;
  localparam logic [3:0] ALL1 = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_chan = '0;
  logic [2:0] req_range = '0;
  logic st_req_valid, st_req_ready;
  logic [6:0] st_req_addr;
  logic st_rsp_valid;
  logic [15:0] st_rsp_data;
  logic ser_data, ser_clk, ref_desel, done;
  logic [3:0] cdac_desel;

  always #5 clk = ~clk;

  caldac_loader u_caldac_loader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_range(req_range), .st_req_valid(st_req_valid),
    .st_req_ready(st_req_ready), .st_req_addr(st_req_addr),
    .st_rsp_valid(st_rsp_valid), .st_rsp_data(st_rsp_data),
    .ser_data(ser_data), .ser_clk(ser_clk), .cdac_desel(cdac_desel),
    .ref_desel(ref_desel), .done(done)
  );

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  function automatic logic [15:0] mw(logic [6:0] a);
    logic [7:0] hi, lo;
    hi = 8'({1'b0, a} * 8'd3 + 8'h11);
    lo = {1'b0, a} ^ 8'hC6;
    return {hi, lo};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // store model: varying grant and response latency
  initial begin
    logic [6:0] a;
    int lat = 0;
    st_req_ready = 1'b0; st_rsp_valid = 1'b0; st_rsp_data = '0;
    forever begin
      @(posedge clk); #1;
      if (st_req_valid) begin
        repeat (lat % 3) begin @(posedge clk); #1; end
        st_req_ready = 1'b1; a = st_req_addr;
        @(posedge clk); #1;
        st_req_ready = 1'b0;
        repeat ((lat + 1) % 2) begin @(posedge clk); #1; end
        st_rsp_valid = 1'b1; st_rsp_data = mw(a);
        @(posedge clk); #1;
        st_rsp_valid = 1'b0;
        lat++;
      end
    end
  end

  // port monitor, sampled at the falling edge
  int nacc = 0, nrd = 0, nf = 0, nbits = 0, ndone = 0, since_clk = 0, lowlen = 0;
  int cyc = 0, acc_cyc = 0, done_cyc = 0;
  logic [6:0] rd_addr [2];
  logic [10:0] frames [4];
  int dacs [4], fbits [4];
  logic [10:0] shreg = '0;
  logic [3:0] prev = 4'hF;
  bit gap_bad = 0, latch_bad = 0, done_after = 0, ref_bad = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!ref_desel) ref_bad = 1;
    if (req_valid && req_ready) begin
      nacc++; acc_cyc = cyc; nrd = 0; nf = 0; nbits = 0; shreg = '0;
      gap_bad = 0; latch_bad = 0;
    end
    if (st_req_valid && st_req_ready) begin
      if (nrd < 2) rd_addr[nrd] = st_req_addr;
      nrd++;
    end
    since_clk++;
    if (ser_clk) begin
      if (nbits != 0 && since_clk != BIT_CYC) gap_bad = 1;
      since_clk = 0;
      shreg = {shreg[9:0], ser_data};
      nbits++;
    end
    if (cdac_desel != ALL1) begin
      if (prev == ALL1) begin
        if (nf < 4) begin
          frames[nf] = shreg; fbits[nf] = nbits;
          for (int i = 0; i < 4; i++) if (!cdac_desel[i]) dacs[nf] = i;
        end
        nf++; nbits = 0; lowlen = 0;
      end
      lowlen++;
    end else if (prev != ALL1) begin
      if (lowlen != LATCH_CYC) latch_bad = 1;
    end
    if (done) begin
      ndone++; done_cyc = cyc;
      done_after = (prev != ALL1) && (cdac_desel == ALL1) && (nf == 4);
    end
    prev = cdac_desel;
  end

  task automatic issue(logic [2:0] c, logic [2:0] r);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_chan = c; req_range = r;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int d0 = ndone;
    int t = 0;
    while (ndone == d0 && t < 3000) begin @(posedge clk); #1; t++; end
    chk(ndone == d0 + 1, "R9 done seen", ndone, d0 + 1);
  endtask

  task automatic check_seq(logic [2:0] c, logic [2:0] r);
    logic [6:0] ia, ib;
    logic [15:0] wo, wg;
    logic [2:0] b;
    logic [10:0] ef [4];
    ia = 7'(2 * r + 12 * c + 7); ib = ia + 7'd1;
    wo = mw(ia); wg = mw(ib);
    b = {c[0], 2'b00};
    ef[0] = {b + 3'd2, wo[15:8]};
    ef[1] = {b + 3'd3, wo[7:0]};
    ef[2] = {b + 3'd1, wg[15:8]};
    ef[3] = {b, wg[7:0]};
    chk(nrd == 2, "R3 two reads", nrd, 2);
    chk(rd_addr[0] == ia, "R2 offset addr", rd_addr[0], ia);
    chk(rd_addr[1] == ib, "R2 gain addr", rd_addr[1], ib);
    chk(nf == 4, "R5 frame count", nf, 4);
    for (int k = 0; k < 4; k++) begin
      chk(frames[k] == ef[k], "R5 frame content", frames[k], ef[k]);
      chk(dacs[k] == int'(c >> 1), "R4 target dac", dacs[k], c >> 1);
      chk(fbits[k] == 11, "R6 bits per frame", fbits[k], 11);
    end
    chk(!gap_bad, "R6 bit window", gap_bad, 0);
    chk(!latch_bad, "R7 latch length", latch_bad, 0);
    chk(done_after, "R9 done placement", done_after, 1);
  endtask

  typedef struct packed { logic [2:0] c; logic [2:0] r; } vec_t;
  localparam vec_t VEC [7] = '{
    '{3'd0, 3'd0}, '{3'd1, 3'd5}, '{3'd2, 3'd3}, '{3'd5, 3'd1},
    '{3'd6, 3'd4}, '{3'd7, 3'd5}, '{3'd3, 3'd2}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(cdac_desel == ALL1, "R1 desel", cdac_desel, ALL1);
    chk(!ser_clk && !done && !st_req_valid, "R1 quiet outputs",
        {ser_clk, done, st_req_valid}, 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      issue(VEC[i].c, VEC[i].r);
      wait_done();
      check_seq(VEC[i].c, VEC[i].r);
      @(posedge clk); #1;
      chk(req_ready, "R9 ready after done", req_ready, 1);
    end

    // R10: request pulsed mid-run is dropped
    begin
      int a0, d0;
      issue(3'd1, 3'd2);
      a0 = nacc;
      repeat (30) @(posedge clk);
      #1;
      chk(!req_ready, "R10 busy", req_ready, 0);
      req_valid = 1'b1; req_chan = 3'd6; req_range = 3'd0;
      @(posedge clk); #1;
      req_valid = 1'b0;
      wait_done();
      check_seq(3'd1, 3'd2);
      d0 = ndone;
      repeat (60) @(posedge clk);
      #1;
      chk(nacc == a0, "R10 no extra accept", nacc, a0);
      chk(ndone == d0 && nf == 4 && nrd == 2, "R10 no extra activity", {ndone, nf}, {d0, 4});
    end

    // R11: held request accepted right after done
    begin
      int a0;
      @(posedge clk); #1;
      a0 = nacc;
      req_valid = 1'b1; req_chan = 3'd4; req_range = 3'd1;
      while (nacc == a0) begin @(posedge clk); #1; end
      req_chan = 3'd7; req_range = 3'd3;
      wait_done();
      check_seq(3'd4, 3'd1);
      while (nacc == a0 + 1) begin @(posedge clk); #1; end
      req_valid = 1'b0;
      chk(acc_cyc == done_cyc + 1, "R11 accept after done", acc_cyc - done_cyc, 1);
      wait_done();
      check_seq(3'd7, 3'd3);
      chk(nacc == a0 + 2, "R11 accept count", nacc, a0 + 2);
    end

    chk(!ref_bad, "R8 ref deselect high", ref_bad, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule